// File: doc/BRIEF.md
# Four-Channel DAC Code Gating Front End

This block is the digital side of a four-channel digital-to-analog converter. It holds one control register and one data register per channel. The registers sit on a simple synchronous read/write bus. For each channel, the block drives an 8-bit code and an active flag to the analog stage. A channel passes its stored code only when its own enable bit is set and idle gating is not in force. Otherwise it drives zero and its active flag is low.

The system power manager drives an idle request input. When idle is requested and the keep-alive bit in the control register is clear, all four channels go quiet, whatever their enable bits say. When the keep-alive bit is set, idle has no effect. Gating never alters what is stored, so reads always return the programmed register values. The gated codes and active flags are registered outputs.

Top module: `dac_front`

## Requirements
- R1: After a synchronous reset, every enable bit, the keep-alive bit and every data register read as 0x00, every output code is 0x00, and every active flag is 0.
- R2: Each channel has its own enable bit, at control bit position equal to the channel number (bits 3:0). Changing one enable bit changes only that channel's outputs.
- R3: A channel whose enable bit is clear outputs code 0x00 and active flag 0, whatever its data register holds.
- R4: A channel that is enabled and not idle-gated outputs its data register value, with active flag 1.
- R5: When idle_req is 1 and keep-alive (control bit 4) is 0, all four channels output 0x00 with active flag 0, regardless of their enable bits.
- R6: When idle_req is 1 and keep-alive is 1, the outputs are the same as with idle_req at 0.
- R7: Address 0 is the control register. Reading it returns bits 3:0 as the enables, bit 4 as keep-alive, and bits 7:5 as zero. Addresses 1 to 4 are the data registers of channels 0 to 3. Addresses 5 to 7 read as 0x00, and writes to them change nothing.
- R8: Outputs are registered. A write taken at clock edge k shows on the outputs after edge k+1. A change of idle_req that is set up before edge k shows on the outputs after edge k.
- R9: Disabling a channel or entering gated idle leaves the stored data and control contents unchanged. A data register written while its channel is off appears on the outputs once the channel becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| idle_req | input | 1 | Idle mode request from the power manager |
| dac_code | output | 32 | Gated codes, channel k in bits 8k+7:8k |
| dac_active | output | 4 | Per-channel active flag, channel k in bit k |

## Verification
The bench sweeps all sixteen enable masks against every combination of idle request and keep-alive, using distinct data per channel. A design that swapped the idle polarity, ignored keep-alive, or leaked one channel's enable into a neighbour would show the wrong code on some channel. Latency is sampled one cycle early and then on time, so a combinational path or an extra register stage is caught. The bench also reads back registers while gating is in force and probes the unused addresses. This catches gating that clears the stored data, reserved control bits that read back as one, and aliased writes that corrupt a data register.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

    localparam int NUM_CH = 4;
    localparam int CODE_W = 8;
    localparam int ADDR_W = $clog2(NUM_CH + 1);
    localparam int KEEP_BIT = NUM_CH;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    typedef struct packed {
        logic              keep_alive;
        logic [NUM_CH-1:0] enable;
    } ctrl_t;

    typedef logic [CODE_W-1:0] code_t;

    function automatic logic chan_runs(input logic en, input logic idle, input logic keep);
        return en && !(idle && !keep);
    endfunction

    function automatic logic [ADDR_W-1:0] data_addr(input int ch);
        return ADDR_W'(ch + 1);
    endfunction

    function automatic code_t ctrl_to_byte(input ctrl_t c);
        code_t b;
        b = '0;
        b[NUM_CH-1:0] = c.enable;
        b[KEEP_BIT]   = c.keep_alive;
        return b;
    endfunction

endpackage

// File: rtl/dac_regfile.sv
module dac_regfile
    import dac_front_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [CODE_W-1:0]        bus_wdata,
    output logic [CODE_W-1:0]        bus_rdata,
    output ctrl_t                    ctrl,
    output logic [NUM_CH*CODE_W-1:0] data_flat
);

    ctrl_t ctrl_q;
    code_t data_q [NUM_CH];
    logic  wr_en;

    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && bus_addr == CTRL_ADDR) begin
            ctrl_q.enable     <= bus_wdata[NUM_CH-1:0];
            ctrl_q.keep_alive <= bus_wdata[KEEP_BIT];
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_data
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[k] <= '0;
            end else if (wr_en && bus_addr == data_addr(k)) begin
                data_q[k] <= bus_wdata;
            end
        end
        assign data_flat[k*CODE_W +: CODE_W] = data_q[k];

        // R9: a data register only moves when its own address is written
        assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && bus_addr == data_addr(k)) |=> $stable(data_q[k]));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata = ctrl_to_byte(ctrl_q);
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (bus_addr == data_addr(k)) begin
                bus_rdata = data_q[k];
            end
        end
    end

    assign ctrl = ctrl_q;

    assert_ctrl_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == CTRL_ADDR) |=>
            (ctrl_q.enable == $past(bus_wdata[NUM_CH-1:0]) &&
             ctrl_q.keep_alive == $past(bus_wdata[KEEP_BIT])));

endmodule

// File: rtl/dac_chan_gate.sv
module dac_chan_gate
    import dac_front_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  code_t data,
    output code_t code_q,
    output logic  active_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            active_q <= 1'b0;
        end else begin
            code_q   <= run ? data : '0;
            active_q <= run;
        end
    end

    // R3: an inactive channel never presents a nonzero code
    assert_off_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> (code_q == '0));

    // R4: a running channel presents its data one edge later
    assert_run_follow_R4: assert property (@(posedge clk) disable iff (rst)
        run |=> (active_q && code_q == $past(data)));

endmodule

// File: rtl/dac_front.sv
module dac_front
    import dac_front_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [CODE_W-1:0]        bus_wdata,
    output logic [CODE_W-1:0]        bus_rdata,
    input  logic                     idle_req,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_active
);

    ctrl_t                    ctrl;
    logic [NUM_CH*CODE_W-1:0] data_flat;
    logic [NUM_CH-1:0]        run;

    dac_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .data_flat (data_flat)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        assign run[k] = chan_runs(ctrl.enable[k], idle_req, ctrl.keep_alive);

        dac_chan_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .run      (run[k]),
            .data     (data_flat[k*CODE_W +: CODE_W]),
            .code_q   (dac_code[k*CODE_W +: CODE_W]),
            .active_q (dac_active[k])
        );
    end

    // R1: the cycle after reset, every channel is quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (dac_active == '0 && dac_code == '0));

    // R5: gated idle silences every channel on the next edge
    assert_idle_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (idle_req && !ctrl.keep_alive) |=> (dac_active == '0));

    // R2: an active flag only rises for a channel whose own enable is set
    assert_own_enable_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((dac_active & ~$past(ctrl.enable)) == '0));

endmodule

// File: tb/dac_front_bench.sv
module dac_front_bench;
    import dac_front_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     bus_sel = 1'b0;
    logic                     bus_wr = 1'b0;
    logic [ADDR_W-1:0]        bus_addr = '0;
    logic [CODE_W-1:0]        bus_wdata = '0;
    logic [CODE_W-1:0]        bus_rdata;
    logic                     idle_req = 1'b0;
    logic [NUM_CH*CODE_W-1:0] dac_code;
    logic [NUM_CH-1:0]        dac_active;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [3:0] m_en = '0;
    logic       m_keep = 1'b0;
    logic [7:0] m_data [4];

    always #4 clk = ~clk;

    dac_front u_dac_front (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .idle_req(idle_req), .dac_code(dac_code), .dac_active(dac_active)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (a == 3'd0) begin
            m_en = d[3:0];
            m_keep = d[4];
        end else if (a >= 3'd1 && a <= 3'd4) begin
            m_data[a - 3'd1] = d;
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outputs(input string req);
        for (int k = 0; k < 4; k++) begin
            logic on;
            on = m_en[k] && !(idle_req && !m_keep);
            chk(req, $sformatf("code ch%0d", k), 32'(dac_code[8*k +: 8]), on ? 32'(m_data[k]) : 32'h0);
            chk(req, $sformatf("active ch%0d", k), 32'(dac_active[k]), 32'(on));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        for (int k = 0; k < 4; k++) m_data[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "code", dac_code, 32'h0);
        chk("R1", "active", 32'(dac_active), 32'h0);
        for (int a = 0; a < 5; a++) begin
            bus_read(3'(a), rd);
            chk("R1", $sformatf("reg %0d", a), 32'(rd), 32'h0);
        end

        // R9: load data while all channels are off; outputs stay quiet (R3)
        for (int k = 0; k < 4; k++) bus_write(3'(k + 1), 8'h3C + 8'(k * 8'h41));
        settle();
        check_outputs("R3");

        // R2 R3 R4 R5 R6: sweep masks against idle and keep-alive
        for (int mask = 0; mask < 16; mask++) begin
            for (int kp = 0; kp < 2; kp++) begin
                for (int id = 0; id < 2; id++) begin
                    bus_write(3'd0, 8'(mask) | (kp[0] ? 8'h10 : 8'h00));
                    idle_req = id[0];
                    settle();
                    if (id == 1 && kp == 0) check_outputs("R5");
                    else if (id == 1) check_outputs("R6");
                    else check_outputs("R2");
                    idle_req = 1'b0;
                end
            end
        end

        // R4: data sweep on enabled channels
        bus_write(3'd0, 8'h0F);
        for (int v = 0; v < 256; v += 15) begin
            for (int k = 0; k < 4; k++) bus_write(3'(k + 1), 8'(v + k * 3));
            settle();
            check_outputs("R4");
        end

        // R8: write latency
        bus_write(3'd2, 8'hA5);
        chk("R8", "code ch1 one cycle early", 32'(dac_code[15:8]), 32'(8'(255 + 3) ));
        settle();
        chk("R8", "code ch1 on time", 32'(dac_code[15:8]), 32'hA5);

        // R8: idle latency, keep-alive clear
        @(negedge clk);
        idle_req = 1'b1;
        #1 chk("R8", "active before edge", 32'(dac_active), 32'hF);
        settle();
        chk("R8", "active after edge", 32'(dac_active), 32'h0);

        // R9: stored contents intact under gated idle
        bus_read(3'd0, rd);
        chk("R9", "ctrl under idle", 32'(rd), 32'h0F);
        for (int k = 0; k < 4; k++) begin
            bus_read(3'(k + 1), rd);
            chk("R9", $sformatf("data %0d under idle", k), 32'(rd), 32'(m_data[k]));
        end
        bus_write(3'd3, 8'h77);
        idle_req = 1'b0;
        settle();
        check_outputs("R9");

        // R7: reserved bits and unused addresses
        bus_write(3'd0, 8'hFF);
        bus_read(3'd0, rd);
        chk("R7", "ctrl reserved bits", 32'(rd), 32'h1F);
        for (int a = 5; a < 8; a++) begin
            bus_write(3'(a), 8'hEE);
            bus_read(3'(a), rd);
            chk("R7", $sformatf("unused addr %0d", a), 32'(rd), 32'h0);
        end
        for (int k = 0; k < 4; k++) begin
            bus_read(3'(k + 1), rd);
            chk("R7", $sformatf("data %0d after unused writes", k), 32'(rd), 32'(m_data[k]));
        end
        settle();
        check_outputs("R7");

        // R1: reset again while active
        @(negedge clk);
        rst = 1'b1;
        settle();
        rst = 1'b0;
        for (int k = 0; k < 4; k++) m_data[k] = '0;
        m_en = '0; m_keep = 1'b0;
        chk("R1", "code after second reset", dac_code, 32'h0);
        bus_read(3'd0, rd);
        chk("R1", "ctrl after second reset", 32'(rd), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule